// File: doc/BRIEF.md
# Core Memory Access Sequencer

This block runs the timing of bit and word accesses to a small coincident-current ferrite core array with 32 cores. A caller chooses an operation, a core address, a data bit or a full word, and raises `start_i`. The sequencer presents an address and a data bit to the external drive decoder. It then raises a drive-enable pulse of fixed length and samples a sense input once, at a fixed delay into that pulse. The sense input is the OR of two comparator outputs, one for each polarity. It goes high only when the addressed core changes its magnetic state.

A core cannot be read without being overwritten. A read therefore drives a 0 into the core first. If the sense input shows that the core switched, the sequencer issues a second pulse that writes the 1 back. An exchange needs only one pulse: it writes the new bit, and the old bit is the sampled sense value XOR the new bit. Word operations repeat the bit sequence for every address. All pulse widths, the sample delay and the recovery gap are counted in clock cycles. Their defaults are derived from a clock-frequency parameter.

Top module: `core_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `drv_en_o` are low.
- R2: Before `drv_en_o` rises, `drv_addr_o` and `drv_data_o` are already stable, and they stay stable while it is high. `drv_en_o` stays high for exactly PULSE_CYC cycles (250 at 125 MHz, which is 2 µs).
- R3: Between any two drive pulses, `drv_en_o` is low for at least GAP_CYC cycles (1 µs by default).
- R4: The sense input is taken only in the pulse cycle with index SAMPLE_CYC, counting the first high cycle as 0 (650 ns by default). Sense activity at the start or end of a pulse, or in the gap, has no effect. The captured sense bit is cleared when each pulse begins.
- R5: Op code 0 (bit write) issues one pulse that carries `wbit_i` to `addr_i`.
- R6: Op code 1 (bit read) drives 0 first. If the sense bit was seen, a second pulse writes 1 back and `rbit_o` is 1. Otherwise there is one pulse and `rbit_o` is 0.
- R7: Op code 2 (exchange) issues one pulse carrying `wbit_i`. `rbit_o` is the sampled sense bit XOR `wbit_i`.
- R8: Op code 3 (word write) issues 32 pulses to addresses 0 to 31 in rising order. Address k carries bit k of `wword_i`.
- R9: Op code 4 (word read) reads addresses 0 to 31 in rising order, each as in R6. Bit k of `rword_o` is the value of core k, and every core that held 1 gets it written back.
- R10: `busy_o` stays high from the cycle after an accepted start until the last gap ends. `done_o` then pulses for one cycle, in the same cycle that `busy_o` falls.
- R11: A start request that arrives while `busy_o` is high has no effect on the running operation or its results.
- R12: Op codes 5 to 7 are not accepted: `busy_o` stays low and no pulse is issued.
- R13: With the default timing, a word operation finishes within 62500 cycles (0.5 ms), even when all 32 cores need a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 3 | Operation code (0 write, 1 read, 2 exchange, 3 word write, 4 word read) |
| addr_i | input | 5 | Core address for bit operations |
| wbit_i | input | 1 | Data bit for write and exchange |
| wword_i | input | 32 | Data word for word write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rbit_o | output | 1 | Result of read or exchange |
| rword_o | output | 32 | Result of word read |
| drv_addr_o | output | 5 | Core address toward the drive decoder |
| drv_data_o | output | 1 | Data bit (drive direction) toward the drive decoder |
| drv_en_o | output | 1 | Drive-current enable pulse |
| sense_i | input | 1 | Thresholded sense signal (OR of both polarities) |

## Verification
The hardest case to reach is a word read in which every core holds 1. Only that case produces the worst-case 64 pulses and the longest run. It also exercises the restore path back to back across every address. To reach it, the bench first writes an all-ones word. It then reads the word back and measures how many cycles the read takes. The core model in the bench raises the sense line at both edges of every pulse and in the gap after it. It raises the switching pulse only when the stored bit would flip, so sampling at the wrong moment shows up as wrong read data. A stray start is injected in the middle of a word write, to show that the running word is not disturbed.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

    typedef enum logic [2:0] {
        OP_WBIT  = 3'd0,
        OP_RBIT  = 3'd1,
        OP_XBIT  = 3'd2,
        OP_WWORD = 3'd3,
        OP_RWORD = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_GAP
    } phase_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/core_pulse_gen.sv
module core_pulse_gen
    import core_seq_pkg::*;
#(
    parameter int SETUP_CYC  = 12,
    parameter int PULSE_CYC  = 250,
    parameter int SAMPLE_CYC = 81,
    parameter int GAP_CYC    = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic en_o,
    output logic strobe_o,
    output logic done_o
);

    localparam int MAXC  = imax(imax(SETUP_CYC, PULSE_CYC), GAP_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } pg_t;

    pg_t pg_d, pg_q;
    logic strobe_d, done_d;

    always_comb begin
        pg_d     = pg_q;
        strobe_d = 1'b0;
        done_d   = 1'b0;
        case (pg_q.ph)
            PH_IDLE: begin
                if (fire_i) begin
                    pg_d.ph  = PH_SETUP;
                    pg_d.cnt = '0;
                end
            end
            PH_SETUP: begin
                if (pg_q.cnt == CNT_W'(SETUP_CYC - 1)) begin
                    pg_d.ph  = PH_HIGH;
                    pg_d.cnt = '0;
                end else begin
                    pg_d.cnt = pg_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                strobe_d = (pg_q.cnt == CNT_W'(SAMPLE_CYC));
                if (pg_q.cnt == CNT_W'(PULSE_CYC - 1)) begin
                    pg_d.ph  = PH_GAP;
                    pg_d.cnt = '0;
                end else begin
                    pg_d.cnt = pg_q.cnt + 1'b1;
                end
            end
            default: begin
                if (pg_q.cnt == CNT_W'(GAP_CYC - 1)) begin
                    pg_d.ph  = PH_IDLE;
                    pg_d.cnt = '0;
                    done_d   = 1'b1;
                end else begin
                    pg_d.cnt = pg_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            pg_q <= pg_d;
        end
    end

    assign en_o     = (pg_q.ph == PH_HIGH);
    assign strobe_o = strobe_d;
    assign done_o   = done_d;

endmodule

// File: rtl/core_sense_latch.sv
module core_sense_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic strobe_i,
    input  logic sense_i,
    output logic bit_o
);

    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q;
        if (clr_i) begin
            bit_d = 1'b0;
        end else if (strobe_i) begin
            bit_d = sense_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_d;
        end
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/core_seq.sv
module core_seq
    import core_seq_pkg::*;
#(
    parameter  int CLK_HZ     = 125_000_000,
    parameter  int ADDR_W     = 5,
    parameter  int SETUP_CYC  = imax(1, CLK_HZ / 10_000_000),
    parameter  int PULSE_CYC  = CLK_HZ / 500_000,
    parameter  int SAMPLE_CYC = (CLK_HZ / 1_000_000) * 650 / 1000,
    parameter  int GAP_CYC    = CLK_HZ / 1_000_000,
    localparam int WORD_W     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wbit_i,
    input  logic [WORD_W-1:0] wword_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rbit_o,
    output logic [WORD_W-1:0] rword_o,
    output logic [ADDR_W-1:0] drv_addr_o,
    output logic              drv_data_o,
    output logic              drv_en_o,
    input  logic              sense_i
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORD_W - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              fire;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic              data;
        logic              restore;
        logic [WORD_W-1:0] wbuf;
        logic [WORD_W-1:0] rword;
        logic              rbit;
    } seq_t;

    seq_t s_d, s_q;

    logic pulse_done, strobe, sensed;
    logic op_ok, is_read, is_word, bit_fin, bit_val;
    logic [ADDR_W-1:0] next_addr;

    core_pulse_gen #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .SAMPLE_CYC(SAMPLE_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (s_q.fire),
        .en_o    (drv_en_o),
        .strobe_o(strobe),
        .done_o  (pulse_done)
    );

    core_sense_latch u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (s_q.fire),
        .strobe_i(strobe),
        .sense_i (sense_i),
        .bit_o   (sensed)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.fire  = 1'b0;
        op_ok     = (op_i <= 3'd4);
        is_read   = (s_q.op == OP_RBIT) || (s_q.op == OP_RWORD);
        is_word   = (s_q.op == OP_WWORD) || (s_q.op == OP_RWORD);
        next_addr = s_q.addr + 1'b1;
        bit_fin   = 1'b1;
        bit_val   = 1'b0;

        if (!s_q.busy) begin
            if (start_i && op_ok) begin
                s_d.busy    = 1'b1;
                s_d.fire    = 1'b1;
                s_d.restore = 1'b0;
                s_d.op      = op_e'(op_i);
                case (op_e'(op_i))
                    OP_WBIT, OP_XBIT: begin
                        s_d.addr = addr_i;
                        s_d.data = wbit_i;
                    end
                    OP_RBIT: begin
                        s_d.addr = addr_i;
                        s_d.data = 1'b0;
                    end
                    OP_WWORD: begin
                        s_d.addr = '0;
                        s_d.data = wword_i[0];
                        s_d.wbuf = wword_i;
                    end
                    default: begin
                        s_d.addr  = '0;
                        s_d.data  = 1'b0;
                        s_d.rword = '0;
                    end
                endcase
            end
        end else if (pulse_done) begin
            if (is_read) begin
                if (!s_q.restore && sensed) begin
                    s_d.restore = 1'b1;
                    s_d.data    = 1'b1;
                    s_d.fire    = 1'b1;
                    bit_fin     = 1'b0;
                end else begin
                    bit_val = s_q.restore;
                end
            end else if (s_q.op == OP_XBIT) begin
                bit_val = sensed ^ s_q.data;
            end

            if (bit_fin) begin
                s_d.restore = 1'b0;
                if ((s_q.op == OP_RBIT) || (s_q.op == OP_XBIT)) begin
                    s_d.rbit = bit_val;
                end
                if (s_q.op == OP_RWORD) begin
                    s_d.rword[s_q.addr] = bit_val;
                end
                if (is_word && (s_q.addr != LAST_ADDR)) begin
                    s_d.addr = next_addr;
                    s_d.data = (s_q.op == OP_WWORD) ? s_q.wbuf[next_addr] : 1'b0;
                    s_d.fire = 1'b1;
                end else begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, done: 1'b0, fire: 1'b0, op: OP_WBIT,
                     addr: '0, data: 1'b0, restore: 1'b0, wbuf: '0,
                     rword: '0, rbit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign done_o     = s_q.done;
    assign rbit_o     = s_q.rbit;
    assign rword_o    = s_q.rword;
    assign drv_addr_o = s_q.addr;
    assign drv_data_o = s_q.data;

endmodule

// File: rtl/core_seq_chk.sv
module core_seq_chk #(
    parameter int ADDR_W    = 5,
    parameter int PULSE_CYC = 250,
    parameter int GAP_CYC   = 125
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] drv_addr_o,
    input logic              drv_data_o,
    input logic              drv_en_o
);

    logic [15:0] hi_cnt, lo_cnt;
    logic        seen_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt     <= '0;
            lo_cnt     <= '0;
            seen_pulse <= 1'b0;
        end else begin
            if (drv_en_o) begin
                hi_cnt     <= hi_cnt + 1'b1;
                lo_cnt     <= '0;
                seen_pulse <= 1'b1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
            end
        end
    end

    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o && $past(drv_en_o) |-> $stable(drv_addr_o) && $stable(drv_data_o)); // R2
    AST_DRV_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_o) |-> $stable(drv_addr_o) && $stable(drv_data_o)); // R2
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en_o) |-> hi_cnt == 16'(PULSE_CYC)); // R2
    AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_o) && seen_pulse |-> lo_cnt >= 16'(GAP_CYC)); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R10
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !drv_en_o); // R12

endmodule

bind core_seq core_seq_chk #(
    .ADDR_W   (ADDR_W),
    .PULSE_CYC(PULSE_CYC),
    .GAP_CYC  (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .drv_addr_o(drv_addr_o),
    .drv_data_o(drv_data_o),
    .drv_en_o  (drv_en_o)
);

// File: tb/sim_core_seq.sv
module sim_core_seq;

    localparam logic [31:0] INIT_MEM = 32'hA5C3_0F96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [4:0]  addr_i = 5'd0;
    logic        wbit_i = 1'b0;
    logic [31:0] wword_i = 32'd0;
    logic        busy_o, done_o, rbit_o, drv_data_o, drv_en_o, sense_i;
    logic [31:0] rword_o;
    logic [4:0]  drv_addr_o;

    int ntests = 0;
    int nfail  = 0;

    always #4 clk = ~clk;

    core_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .addr_i(addr_i), .wbit_i(wbit_i), .wword_i(wword_i),
        .busy_o(busy_o), .done_o(done_o), .rbit_o(rbit_o), .rword_o(rword_o),
        .drv_addr_o(drv_addr_o), .drv_data_o(drv_data_o), .drv_en_o(drv_en_o),
        .sense_i(sense_i)
    );

    // Core array model: spikes at both pulse edges, switching pulse only on a flip
    logic [31:0] core_m;
    logic        en_q, flip_q, d_cap, seen_fall;
    logic [4:0]  a_cap;
    int          hc, lc;

    always @(posedge clk) begin
        if (!rst_n) begin
            core_m <= INIT_MEM; en_q <= 1'b0; flip_q <= 1'b0; d_cap <= 1'b0;
            a_cap <= 5'd0; hc <= 0; lc <= 0; seen_fall <= 1'b0;
        end else begin
            en_q <= drv_en_o;
            if (drv_en_o && !en_q) begin
                hc <= 1; flip_q <= (core_m[drv_addr_o] != drv_data_o);
                a_cap <= drv_addr_o; d_cap <= drv_data_o;
            end else if (drv_en_o) begin
                hc <= hc + 1;
            end
            if (!drv_en_o && en_q) begin
                core_m[a_cap] <= d_cap; lc <= 1; seen_fall <= 1'b1;
            end else if (!drv_en_o) begin
                lc <= lc + 1;
            end
        end
    end

    assign sense_i = (drv_en_o && (!en_q || hc < 3))
                   || (drv_en_o && en_q && flip_q && hc >= 30 && hc <= 110)
                   || (!drv_en_o && en_q)
                   || (!drv_en_o && seen_fall && lc < 3);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct {
        int          op;
        int          pulses;
        logic        rbit;
        logic [31:0] rword;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    logic [31:0] ref_mem;
    int          pcnt, cyc;
    logic        en_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (start_i && !busy_o) begin
                pcnt = 0; cyc = 0;
            end
            if (busy_o) cyc++;
            if (drv_en_o && !en_prev) pcnt++;
            if (done_o) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(pcnt == e.pulses, e.req, "pulse count", pcnt, e.pulses);
                    if (e.op == 1 || e.op == 2)
                        check(rbit_o == e.rbit, e.req, "rbit", rbit_o, e.rbit);
                    if (e.op == 4)
                        check(rword_o == e.rword, e.req, "rword", rword_o, e.rword);
                    if (e.op >= 3)
                        check(cyc <= 62500, "R13", "word op cycles", cyc, 62500);
                end
            end
        end
        en_prev = drv_en_o;
    end

    task automatic drive_start(input logic [2:0] op, input logic [4:0] a,
                               input logic b, input logic [31:0] w);
        @(posedge clk); #2;
        start_i = 1'b1; op_i = op; addr_i = a; wbit_i = b; wword_i = w;
        @(posedge clk); #2;
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [4:0] a,
                          input logic b, input logic [31:0] w,
                          input string req, input bit stray);
        exp_t e;
        e.op = int'(op); e.req = req; e.rbit = 1'b0; e.rword = 32'd0;
        case (op)
            3'd0: begin e.pulses = 1; ref_mem[a] = b; end
            3'd1: begin e.rbit = ref_mem[a]; e.pulses = 1 + int'(ref_mem[a]); end
            3'd2: begin e.rbit = ref_mem[a]; e.pulses = 1; ref_mem[a] = b; end
            3'd3: begin e.pulses = 32; ref_mem = w; end
            default: begin e.rword = ref_mem; e.pulses = 32 + $countones(ref_mem); end
        endcase
        sbq.push_back(e);
        drive_start(op, a, b, w);
        if (stray) begin
            // R11: start a bit write to core 3 with 0 in the middle of the word
            repeat (2000) @(posedge clk);
            #2; start_i = 1'b1; op_i = 3'd0; addr_i = 5'd3; wbit_i = 1'b0;
            @(posedge clk); #2; start_i = 1'b0;
        end
        wait_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        ref_mem = INIT_MEM;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        check(drv_en_o == 1'b0, "R1", "enable after reset", drv_en_o, 0);
        @(posedge clk); #2; rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_op(3'd1, 5'd1, 1'b0, 32'd0, "R6", 1'b0);   // core 1 holds 1: restore
        run_op(3'd1, 5'd0, 1'b0, 32'd0, "R4", 1'b0);   // core 0 holds 0 despite spikes
        run_op(3'd0, 5'd0, 1'b1, 32'd0, "R5", 1'b0);
        run_op(3'd1, 5'd0, 1'b0, 32'd0, "R5", 1'b0);   // read back written 1
        run_op(3'd2, 5'd3, 1'b1, 32'd0, "R7", 1'b0);   // old 0
        run_op(3'd2, 5'd3, 1'b0, 32'd0, "R7", 1'b0);   // old 1
        run_op(3'd2, 5'd2, 1'b1, 32'd0, "R7", 1'b0);   // no flip, old 1
        run_op(3'd4, 5'd0, 1'b0, 32'd0, "R9", 1'b0);
        run_op(3'd3, 5'd0, 1'b0, 32'hFFFF_FFFF, "R8", 1'b1);
        check(busy_o == 1'b0, "R11", "busy after stray start", busy_o, 0);
        run_op(3'd4, 5'd0, 1'b0, 32'd0, "R11", 1'b0);  // all ones, 64 pulses, R13
        run_op(3'd3, 5'd0, 1'b0, 32'h1234_5678, "R8", 1'b0);
        run_op(3'd4, 5'd0, 1'b0, 32'd0, "R9", 1'b0);
        check(core_m == 32'h1234_5678, "R9", "array after read", core_m, 32'h1234_5678);

        // R12: unused op code
        drive_start(3'd6, 5'd4, 1'b1, 32'd0);
        repeat (20) @(negedge clk);
        check(busy_o == 1'b0, "R12", "busy after op 6", busy_o, 0);
        check(pcnt == 0, "R12", "pulses after op 6", pcnt, 0);
        check(sbq.size() == 0, "R10", "pending results", sbq.size(), 0);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule